// File: doc/BRIEF.md
# NAND Prefetch Engine Control and Status

This block holds the programmable state of a NAND prefetch and write-posting engine inside a memory controller. Software programs two configuration words and a start control over a 32-bit register bus. The first configuration word carries a direction bit and a FIFO threshold. The second carries the transfer length. The block does not move data. It keeps the bookkeeping that a data mover would later update: a FIFO fill level and a transfer count. It also packs both values into a read-only status word.

A start write preloads the fill level from the direction bit. A write-posting transfer starts with a full FIFO of 64 entries. A read-prefetch transfer starts with an empty FIFO. The same start write loads the transfer count from the length field. A comparator checks the fill level against the threshold, and a registered copy of that result leaves the block as a request line for a DMA or interrupt controller.

The engine runs a two-state machine. Its states are `PFE_IDLE` and `PFE_RUN`, and it has three transitions:
- **start**: `PFE_IDLE` to `PFE_RUN` on a control write with bit 0 = 1.
- **restart**: `PFE_RUN` to `PFE_RUN` on a control write with bit 0 = 1. This reloads the level and the count.
- **stop**: any state to `PFE_IDLE` on a control write with bit 0 = 0.

Top module: `pfetch_ctl`

## Requirements
- R1: After reset the registers read as follows, and `thr_req` is 0:
  - word 0 reads 0x00004000;
  - word 1 reads 0;
  - word 2 reads 0;
  - word 3 reads 0.
- R2: Word address 0 is configuration A. A write keeps only the bits under mask 0x7F8F7FBF, and a read returns the stored value. Bit 0 is the direction bit: 1 selects write posting and 0 selects read prefetch. Bits 14:8 are the threshold.
- R3: Word address 1 is configuration B. A write keeps only the bits under mask 0x00003FFF. Bits 13:0 are the transfer length.
- R4: Word address 2 is the control word. It stores only bit 0, which reads 1 while the engine is in `PFE_RUN` and 0 in `PFE_IDLE`.
- R5: A control write with bit 0 = 1 loads two values, in either state:
  - the fill level, with 64 when the direction bit is 1 and with 0 when it is 0;
  - the count, with configuration B bits 13:0.
- R6: A control write with bit 0 = 0 returns the engine to `PFE_IDLE` and leaves the fill level and the count unchanged.
- R7: Word address 3 is the status word. Its fields are:
  - bits 31:24, the fill level;
  - bit 16, the threshold flag;
  - bits 13:0, the count;
  - every other bit, 0.
- R8: The threshold flag is 1 exactly when the fill level is strictly greater than configuration A bits 14:8.
- R9: `thr_req` equals the threshold flag as it stood one clock cycle earlier.
- R10: A write to the status word changes no register. Configuration A, configuration B, the control word and the status word all read the same before and after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| thr_req | output | 1 | Registered threshold-reached request |

## Verification
The bench builds the block with its default parameters: an 8-bit level field, a 7-bit threshold, a 14-bit count and a full level of 64. With a 7-bit threshold, every threshold value from 0 to 127 can be swept under both directions. The sweep therefore covers the comparison boundary at 63 and 64, the empty-FIFO case that never raises the flag, and the one-cycle lag of `thr_req`. A different length is written before each start, so every start also checks that the count loads and that the upper write bits are masked.

// File: rtl/pfetch_pkg.sv
package pfetch_pkg;
    typedef enum logic [0:0] {
        PFE_IDLE = 1'b0,
        PFE_RUN  = 1'b1
    } pfe_state_e;

    localparam int REG_CFG_A = 0;
    localparam int REG_CFG_B = 1;
    localparam int REG_CTRL  = 2;
    localparam int REG_STAT  = 3;
endpackage

// File: rtl/pfetch_cfg_regs.sv
module pfetch_cfg_regs #(
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 2,
    parameter logic [DATA_W-1:0] CFG_A_RST  = 32'h0000_4000,
    parameter logic [DATA_W-1:0] CFG_A_MASK = 32'h7F8F_7FBF,
    parameter logic [DATA_W-1:0] CFG_B_RST  = 32'h0000_0000,
    parameter logic [DATA_W-1:0] CFG_B_MASK = 32'h0000_3FFF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    output logic [1:0][DATA_W-1:0] cfg_o
);
    import pfetch_pkg::*;

    for (genvar i = 0; i < 2; i++) begin : g_cfg
        localparam logic [DATA_W-1:0] RST = (i == 0) ? CFG_A_RST : CFG_B_RST;
        localparam logic [DATA_W-1:0] MSK = (i == 0) ? CFG_A_MASK : CFG_B_MASK;
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(REG_CFG_A + i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_o[i] <= RST;
            end else if (wr_i && (addr_i == IDX)) begin
                cfg_o[i] <= wdata_i & MSK;
            end
        end
    end
endmodule

// File: rtl/pfetch_engine.sv
module pfetch_engine #(
    parameter int LEVEL_W    = 8,
    parameter int CNT_W      = 14,
    parameter int FULL_LEVEL = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr_i,
    input  logic               ctrl_bit_i,
    input  logic               dir_post_i,
    input  logic [CNT_W-1:0]   cnt_init_i,
    output logic               run_o,
    output logic [LEVEL_W-1:0] level_o,
    output logic [CNT_W-1:0]   count_o
);
    import pfetch_pkg::*;

    localparam logic [LEVEL_W-1:0] LVL_FULL  = LEVEL_W'(FULL_LEVEL);
    localparam logic [LEVEL_W-1:0] LVL_EMPTY = '0;

    pfe_state_e state_q, state_d;
    logic       start_evt;
    logic       stop_evt;

    assign start_evt = ctrl_wr_i &  ctrl_bit_i;
    assign stop_evt  = ctrl_wr_i & ~ctrl_bit_i;

    // transitions: start, restart, stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PFE_IDLE: if (start_evt) state_d = PFE_RUN;
            PFE_RUN:  if (stop_evt)  state_d = PFE_IDLE;
            default:  state_d = PFE_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PFE_IDLE;
        else        state_q <= state_d;
    end

    // outputs: level and count bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_o <= LVL_EMPTY;
            count_o <= '0;
        end else if (start_evt) begin
            level_o <= dir_post_i ? LVL_FULL : LVL_EMPTY;
            count_o <= cnt_init_i;
        end
    end

    assign run_o = (state_q == PFE_RUN);
endmodule

// File: rtl/pfetch_status.sv
module pfetch_status #(
    parameter int DATA_W    = 32,
    parameter int LEVEL_W   = 8,
    parameter int CNT_W     = 14,
    parameter int THR_W     = 7,
    parameter int FLAG_BIT  = 16
) (
    input  logic [LEVEL_W-1:0] level_i,
    input  logic [CNT_W-1:0]   count_i,
    input  logic [THR_W-1:0]   thr_i,
    output logic               flag_o,
    output logic [DATA_W-1:0]  word_o
);
    localparam int LEVEL_LSB = DATA_W - LEVEL_W;

    assign flag_o = (level_i > LEVEL_W'(thr_i));

    always_comb begin
        word_o                       = '0;
        word_o[LEVEL_LSB +: LEVEL_W] = level_i;
        word_o[FLAG_BIT]             = flag_o;
        word_o[CNT_W-1:0]            = count_i;
    end
endmodule

// File: rtl/pfetch_ctl.sv
module pfetch_ctl #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 2,
    parameter int LEVEL_W    = 8,
    parameter int CNT_W      = 14,
    parameter int THR_W      = 7,
    parameter int THR_LSB    = 8,
    parameter int DIR_BIT    = 0,
    parameter int FLAG_BIT   = 16,
    parameter int FULL_LEVEL = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              thr_req
);
    import pfetch_pkg::*;

    localparam logic [ADDR_W-1:0] A_CFG_A = ADDR_W'(REG_CFG_A);
    localparam logic [ADDR_W-1:0] A_CFG_B = ADDR_W'(REG_CFG_B);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(REG_STAT);

    logic [1:0][DATA_W-1:0] cfg;
    logic [DATA_W-1:0]      cfg_a;
    logic [DATA_W-1:0]      cfg_b;
    logic                   run;
    logic [LEVEL_W-1:0]     level;
    logic [CNT_W-1:0]       count;
    logic                   thr_flag;
    logic [DATA_W-1:0]      stat_word;
    logic                   ctrl_wr;

    assign cfg_a   = cfg[0];
    assign cfg_b   = cfg[1];
    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);

    pfetch_cfg_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .cfg_o   (cfg)
    );

    pfetch_engine #(
        .LEVEL_W    (LEVEL_W),
        .CNT_W      (CNT_W),
        .FULL_LEVEL (FULL_LEVEL)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr_i  (ctrl_wr),
        .ctrl_bit_i (reg_wdata[0]),
        .dir_post_i (cfg_a[DIR_BIT]),
        .cnt_init_i (cfg_b[CNT_W-1:0]),
        .run_o      (run),
        .level_o    (level),
        .count_o    (count)
    );

    pfetch_status #(
        .DATA_W   (DATA_W),
        .LEVEL_W  (LEVEL_W),
        .CNT_W    (CNT_W),
        .THR_W    (THR_W),
        .FLAG_BIT (FLAG_BIT)
    ) u_stat (
        .level_i (level),
        .count_i (count),
        .thr_i   (cfg_a[THR_LSB +: THR_W]),
        .flag_o  (thr_flag),
        .word_o  (stat_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thr_req <= 1'b0;
        else        thr_req <= thr_flag;
    end

    always_comb begin
        unique case (reg_addr)
            A_CFG_A: reg_rdata = cfg_a;
            A_CFG_B: reg_rdata = cfg_b;
            A_CTRL:  reg_rdata = {{(DATA_W-1){1'b0}}, run};
            A_STAT:  reg_rdata = stat_word;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pfetch_ctl_chk.sv
module pfetch_ctl_chk #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 2,
    parameter int LEVEL_W    = 8,
    parameter int CNT_W      = 14,
    parameter int FLAG_BIT   = 16,
    parameter int FULL_LEVEL = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               thr_req,
    input logic [DATA_W-1:0]  cfg_a,
    input logic [DATA_W-1:0]  cfg_b,
    input logic               run,
    input logic [LEVEL_W-1:0] level,
    input logic [CNT_W-1:0]   count,
    input logic [DATA_W-1:0]  stat_word
);
    import pfetch_pkg::*;

    localparam logic [ADDR_W-1:0]  A_CTRL = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0]  A_STAT = ADDR_W'(REG_STAT);
    localparam logic [LEVEL_W-1:0] LFULL  = LEVEL_W'(FULL_LEVEL);

    assert_cfg_a_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_a & ~32'h7F8F_7FBF) == '0);

    assert_cfg_b_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_b & ~32'h0000_3FFF) == '0);

    assert_ctrl_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CTRL) |-> (reg_rdata == {{(DATA_W-1){1'b0}}, run}));

    assert_start_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && reg_wdata[0]) |=>
        (run && level == ($past(cfg_a[0]) ? LFULL : '0)
             && count == $past(cfg_b[CNT_W-1:0])));

    assert_stop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && !reg_wdata[0]) |=>
        (!run && $stable(level) && $stable(count)));

    assert_thr_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        thr_req == $past(stat_word[FLAG_BIT]));

    assert_stat_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STAT) |=>
        ($stable(stat_word) && $stable(cfg_a) && $stable(cfg_b) && $stable(run)));
endmodule

bind pfetch_ctl pfetch_ctl_chk #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .LEVEL_W    (LEVEL_W),
    .CNT_W      (CNT_W),
    .FLAG_BIT   (FLAG_BIT),
    .FULL_LEVEL (FULL_LEVEL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .thr_req   (thr_req),
    .cfg_a     (cfg_a),
    .cfg_b     (cfg_b),
    .run       (run),
    .level     (level),
    .count     (count),
    .stat_word (stat_word)
);

// File: tb/pfetch_ctl_tb.sv
module pfetch_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        thr_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pfetch_ctl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .thr_req   (thr_req)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] stat_exp(int lvl, int thr, int cnt);
        return (32'(lvl) << 24) | ((lvl > thr) ? 32'h0001_0000 : 32'h0) | 32'(cnt);
    endfunction

    initial begin
        logic [31:0] d;
        logic [31:0] s_before;
        int lvl;
        int cnt;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values
        rd(2'd0, d); chk("R1 cfgA", d, 32'h0000_4000);
        rd(2'd1, d); chk("R1 cfgB", d, 32'h0);
        rd(2'd2, d); chk("R1 ctrl", d, 32'h0);
        rd(2'd3, d); chk("R1 status", d, 32'h0);
        chk("R1 thr_req", {31'b0, thr_req}, 32'h0);

        // R2 / R3 / R4 masks
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); chk("R2 mask ones", d, 32'h7F8F_7FBF);
        wr(2'd0, 32'h0);         rd(2'd0, d); chk("R2 mask zero", d, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); chk("R3 mask ones", d, 32'h0000_3FFF);
        wr(2'd2, 32'hFFFF_FFFE); rd(2'd2, d); chk("R4 ctrl bit0 clear", d, 32'h0);
        wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, d); chk("R4 ctrl running", d, 32'h1);

        // R5 R7 R8 R9 sweep over direction and every threshold
        for (int dir = 0; dir < 2; dir++) begin
            for (int thr = 0; thr < 128; thr++) begin
                cnt = (thr * 131 + dir * 77 + 5) & 16'h3FFF;
                lvl = dir ? 64 : 0;
                wr(2'd0, 32'(dir) | (32'(thr) << 8));
                wr(2'd1, 32'hABCD_0000 | 32'(cnt));
                wr(2'd2, 32'h1);
                rd(2'd3, d); chk("R5 R7 R8 status after start", d, stat_exp(lvl, thr, cnt));
                @(posedge clk); @(negedge clk);
                chk("R9 thr_req", {31'b0, thr_req}, {31'b0, (lvl > thr)});
            end
        end

        // R6 stop keeps level and count
        rd(2'd3, s_before);
        wr(2'd2, 32'h0);
        rd(2'd2, d); chk("R6 ctrl after stop", d, 32'h0);
        rd(2'd3, d); chk("R6 status held", d, s_before);

        // R5 restart in run reloads count
        wr(2'd0, 32'h0000_1001);
        wr(2'd1, 32'h0000_1234);
        wr(2'd2, 32'h1);
        wr(2'd1, 32'h0000_0777);
        wr(2'd2, 32'h1);
        rd(2'd3, d); chk("R5 restart reload", d, stat_exp(64, 16, 32'h777));
        rd(2'd2, d); chk("R5 still running", d, 32'h1);

        // R10 status write ignored
        rd(2'd3, s_before);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, d); chk("R10 status unchanged", d, s_before);
        rd(2'd0, d); chk("R10 cfgA unchanged", d, 32'h0000_1001);
        rd(2'd1, d); chk("R10 cfgB unchanged", d, 32'h0000_0777);
        rd(2'd2, d); chk("R10 ctrl unchanged", d, 32'h1);

        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule